// File: doc/BRIEF.md
# Four-Channel Hardware Breakpoint Unit

The unit holds four breakpoint linear addresses, a control word and a status word. It watches every memory access and instruction fetch that the core presents on its observation port. When an access matches an enabled breakpoint, it raises a one-cycle debug exception request and records which breakpoints were hit. Each breakpoint is set to match either instruction fetches or data accesses, and data breakpoints can be set to match writes only or both reads and writes. Each breakpoint also covers a region of 1, 2 or 4 aligned bytes. A breakpoint counts when its local or its global enable is set.

Only privilege level 0 may use the register port. A request made at any other level, or to an unused select code, is answered with an error pulse and changes nothing. The status word is read-only through the port. Its hit bits and its two single-step/task bits stay set until the exception handler model drives the clear input.

Top module: `hw_bkpt_unit`

## Requirements
- R1: Select codes 0 to 3 address breakpoint address registers 0 to 3. After a write at privilege 0, a read of the same code returns the 32-bit value written.
- R2: Select code 4 is the control word. Bits 31..16 (type in bits 16+4n..17+4n, size in 18+4n..19+4n for breakpoint n), bits 7..0 (local enable at bit 2n, global enable at bit 2n+1) and bit 13 are writable. Bit 10 always reads 1. Every other bit reads 0, and writes to those bits are ignored.
- R3: Select code 5 is the status word. Bits 3..0 are the hit bits of breakpoints 3..0, bit 14 is the single-step bit and bit 15 is the task bit. Bits 11..4 read 1 and all other bits read 0. Writes to code 5 are ignored.
- R4: A request with priv_lvl_i not 0, or with select code 6 or 7, sets reg_err_o in the next cycle, returns read data 0, and leaves every register unchanged.
- R5: Type 00 is an execute breakpoint. It matches only fetches (kind 00), and only when the fetched byte range contains the exact breakpoint byte; the size field is ignored for it.
- R6: Type 01 matches writes only (kind 10). Type 11 matches reads (kind 01) and writes. Type 10 never matches. Access kind 11 is idle and never matches.
- R7: For data breakpoints, size 00 covers 1 byte, 01 covers 2 bytes and 10 or 11 covers 4 bytes, aligned down from the stored address. Access size 00 covers 1 byte, 01 covers 2 bytes and 1x covers 4 bytes, starting at the access address. A match requires the two byte ranges to overlap.
- R8: A breakpoint matches only while its local or its global enable bit is set.
- R9: dbg_exc_o is high in the cycle after an observed access that matches any enabled breakpoint, and only then.
- R10: Each match sets its hit bit at the same edge as dbg_exc_o. Hit bits stay set until stat_clr_i is asserted. A match in the clear cycle survives the clear.
- R11: ss_set_i and task_set_i set status bits 14 and 15. These bits stay set until stat_clr_i is asserted, and a set in the clear cycle wins.
- R12: Read data and the error flag appear in the cycle after the request and are 0 in any cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register port request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 3 | Register select code |
| reg_wdata_i | input | 32 | Write data |
| priv_lvl_i | input | 2 | Current privilege level of the requester |
| reg_rdata_o | output | 32 | Read data, one cycle after the request |
| reg_err_o | output | 1 | Rejected request, one cycle after the request |
| acc_valid_i | input | 1 | An access is being observed |
| acc_addr_i | input | 32 | Linear address of the access |
| acc_kind_i | input | 2 | 00 fetch, 01 read, 10 write, 11 idle |
| acc_size_i | input | 2 | 00 one byte, 01 two bytes, 1x four bytes |
| ss_set_i | input | 1 | Sets the single-step status bit |
| task_set_i | input | 1 | Sets the task status bit |
| stat_clr_i | input | 1 | Clears all sticky status bits |
| dbg_exc_o | output | 1 | Debug exception request pulse |

## Verification
A new breakpoint hit and the handler's status clear can arrive in the same cycle. The bench provokes this by asserting stat_clr_i while it presents a matching access. It then reads the status word and expects only the new hit bits to remain. Single-step and task set pulses are also applied together with a clear, and the bench expects those bits to survive. A reference model in the bench computes hits byte by byte. Constrained random accesses placed near the stored addresses check this model against dbg_exc_o and the read-back hit bits.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  parameter int unsigned NUM_BP = 4;
  parameter int unsigned DW     = 32;
  parameter int unsigned SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(NUM_BP);
  localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_BP + 1);

  localparam logic [DW-1:0] CTRL_WMASK = 32'hFFFF_20FF;
  localparam logic [DW-1:0] CTRL_ONES  = 32'h0000_0400;

  localparam int unsigned CFG_LSB = 16;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_IDLE  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    BT_EXEC = 2'b00,
    BT_WR   = 2'b01,
    BT_NONE = 2'b10,
    BT_RW   = 2'b11
  } bp_type_e;

  typedef struct packed {
    logic [1:0] len;
    logic [1:0] kind;
  } bp_cfg_t;
endpackage

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
  import bkpt_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [DW-1:0]               wdata_i,
  input  logic [1:0]                  priv_i,
  input  logic [DW-1:0]               stat_i,
  output logic [DW-1:0]               rdata_o,
  output logic                        err_o,
  output logic [NUM_BP-1:0][DW-1:0]   bp_addr_o,
  output logic [DW-1:0]               ctrl_o
);
  logic                      ok;
  logic                      wr_ok;
  logic [NUM_BP-1:0][DW-1:0] addr_q;
  logic [DW-1:0]             ctrl_q;
  logic [DW-1:0]             rd_val;
  logic [DW-1:0]             rdata_q;
  logic                      err_q;

  assign ok    = req_i && (priv_i == 2'd0) && (sel_i <= SEL_STAT);
  assign wr_ok = ok && we_i;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_addr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                addr_q[i] <= '0;
      else if (wr_ok && sel_i == SEL_W'(i))       addr_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           ctrl_q <= '0;
    else if (wr_ok && sel_i == SEL_CTRL)   ctrl_q <= wdata_i & CTRL_WMASK;
  end

  always_comb begin
    rd_val = '0;
    if (sel_i < SEL_CTRL)        rd_val = addr_q[sel_i[1:0]];
    else if (sel_i == SEL_CTRL)  rd_val = ctrl_q | CTRL_ONES;
    else if (sel_i == SEL_STAT)  rd_val = stat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (ok && !we_i) ? rd_val : '0;
      err_q   <= req_i && !ok;
    end
  end

  assign rdata_o   = rdata_q;
  assign err_o     = err_q;
  assign bp_addr_o = addr_q;
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
(
  input  logic          en_i,
  input  logic [DW-1:0] bp_addr_i,
  input  bp_cfg_t       cfg_i,
  input  logic          acc_valid_i,
  input  logic [DW-1:0] acc_addr_i,
  input  logic [1:0]    acc_kind_i,
  input  logic [1:0]    acc_size_i,
  output logic          hit_o
);
  acc_kind_e   kind;
  bp_type_e    btype;
  logic [1:0]  bp_span;
  logic [1:0]  acc_span;
  logic [DW-1:0] base;
  logic [DW:0]   bp_end;
  logic [DW:0]   acc_lo;
  logic [DW:0]   acc_end;
  logic          type_ok;
  logic          overlap;

  assign kind  = acc_kind_e'(acc_kind_i);
  assign btype = bp_type_e'(cfg_i.kind);

  // execute breakpoints always cover one byte
  always_comb begin
    if (btype == BT_EXEC)       bp_span = 2'd0;
    else if (cfg_i.len == 2'b00) bp_span = 2'd0;
    else if (cfg_i.len == 2'b01) bp_span = 2'd1;
    else                         bp_span = 2'd3;
  end

  always_comb begin
    case (acc_size_i)
      2'b00:   acc_span = 2'd0;
      2'b01:   acc_span = 2'd1;
      default: acc_span = 2'd3;
    endcase
  end

  assign base    = bp_addr_i & ~{{(DW-2){1'b0}}, bp_span};
  assign bp_end  = {1'b0, base} + {{(DW-1){1'b0}}, bp_span};
  assign acc_lo  = {1'b0, acc_addr_i};
  assign acc_end = acc_lo + {{(DW-1){1'b0}}, acc_span};
  assign overlap = (acc_lo <= bp_end) && (acc_end >= {1'b0, base});

  always_comb begin
    case (btype)
      BT_EXEC: type_ok = (kind == ACC_FETCH);
      BT_WR:   type_ok = (kind == ACC_WRITE);
      BT_RW:   type_ok = (kind == ACC_READ) || (kind == ACC_WRITE);
      default: type_ok = 1'b0;
    endcase
  end

  assign hit_o = acc_valid_i && en_i && type_ok && overlap;
endmodule

// File: rtl/bkpt_status.sv
module bkpt_status
  import bkpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_BP-1:0] hit_i,
  input  logic              ss_set_i,
  input  logic              task_set_i,
  input  logic              clr_i,
  output logic [NUM_BP-1:0] b_o,
  output logic              ss_o,
  output logic              task_o,
  output logic              exc_o
);
  logic [NUM_BP-1:0] b_q;
  logic              ss_q;
  logic              task_q;
  logic              exc_q;

  // new events in the clear cycle survive the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_q    <= '0;
      ss_q   <= 1'b0;
      task_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      b_q    <= (clr_i ? '0 : b_q) | hit_i;
      ss_q   <= (ss_q & ~clr_i) | ss_set_i;
      task_q <= (task_q & ~clr_i) | task_set_i;
      exc_q  <= |hit_i;
    end
  end

  assign b_o    = b_q;
  assign ss_o   = ss_q;
  assign task_o = task_q;
  assign exc_o  = exc_q;
endmodule

// File: rtl/hw_bkpt_unit.sv
module hw_bkpt_unit
  import bkpt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_req_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  input  logic [1:0]  priv_lvl_i,
  output logic [31:0] reg_rdata_o,
  output logic        reg_err_o,
  input  logic        acc_valid_i,
  input  logic [31:0] acc_addr_i,
  input  logic [1:0]  acc_kind_i,
  input  logic [1:0]  acc_size_i,
  input  logic        ss_set_i,
  input  logic        task_set_i,
  input  logic        stat_clr_i,
  output logic        dbg_exc_o
);
  logic [NUM_BP-1:0][DW-1:0] bp_addr;
  logic [DW-1:0]             ctrl_word;
  logic [DW-1:0]             stat_word;
  logic [NUM_BP-1:0]         hit;
  logic [NUM_BP-1:0]         stat_b;
  logic                      stat_ss;
  logic                      stat_task;

  assign stat_word = {16'h0000, stat_task, stat_ss, 2'b00, 8'hFF, stat_b};

  bkpt_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (reg_req_i),
    .we_i      (reg_we_i),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .priv_i    (priv_lvl_i),
    .stat_i    (stat_word),
    .rdata_o   (reg_rdata_o),
    .err_o     (reg_err_o),
    .bp_addr_o (bp_addr),
    .ctrl_o    (ctrl_word)
  );

  for (genvar n = 0; n < NUM_BP; n++) begin : g_cmp
    bkpt_cmp u_cmp (
      .en_i        (ctrl_word[2*n] | ctrl_word[2*n+1]),
      .bp_addr_i   (bp_addr[n]),
      .cfg_i       (bp_cfg_t'(ctrl_word[CFG_LSB+4*n +: 4])),
      .acc_valid_i (acc_valid_i),
      .acc_addr_i  (acc_addr_i),
      .acc_kind_i  (acc_kind_i),
      .acc_size_i  (acc_size_i),
      .hit_o       (hit[n])
    );
  end

  bkpt_status u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .ss_set_i   (ss_set_i),
    .task_set_i (task_set_i),
    .clr_i      (stat_clr_i),
    .b_o        (stat_b),
    .ss_o       (stat_ss),
    .task_o     (stat_task),
    .exc_o      (dbg_exc_o)
  );
endmodule

// File: rtl/bkpt_checker.sv
module bkpt_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_req_i,
  input logic        reg_we_i,
  input logic [2:0]  reg_sel_i,
  input logic [1:0]  priv_lvl_i,
  input logic [31:0] reg_rdata_o,
  input logic        reg_err_o,
  input logic        stat_clr_i,
  input logic        dbg_exc_o,
  input logic [3:0]  stat_b,
  input logic [31:0] ctrl_word
);
  p_priv_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && priv_lvl_i != 2'd0 |=> reg_err_o && reg_rdata_o == 32'h0);

  p_sel_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && reg_sel_i > 3'd5 |=> reg_err_o);

  p_ctrl_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && reg_sel_i == 3'd4 && priv_lvl_i == 2'd0
    |=> reg_rdata_o[10] && reg_rdata_o[15:14] == 2'b00 && reg_rdata_o[12:11] == 2'b00
        && reg_rdata_o[9:8] == 2'b00 && !reg_err_o);

  p_stat_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && reg_sel_i == 3'd5 && priv_lvl_i == 2'd0
    |=> reg_rdata_o[11:4] == 8'hFF && reg_rdata_o[31:16] == 16'h0 && reg_rdata_o[13:12] == 2'b00);

  p_idle_port_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_req_i |=> reg_rdata_o == 32'h0 && !reg_err_o);

  p_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_word[7:0] == 8'h00 |=> !dbg_exc_o);

  p_exc_marks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_exc_o |-> stat_b != 4'h0);

  for (genvar i = 0; i < 4; i++) begin : g_sticky
    p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_b[i] && !stat_clr_i |=> stat_b[i]);
  end
endmodule

bind hw_bkpt_unit bkpt_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .priv_lvl_i  (priv_lvl_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_err_o   (reg_err_o),
  .stat_clr_i  (stat_clr_i),
  .dbg_exc_o   (dbg_exc_o),
  .stat_b      (stat_b),
  .ctrl_word   (ctrl_word)
);

// File: tb/hw_bkpt_unit_bench.sv
module hw_bkpt_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [1:0]  priv_lvl_i = '0;
  logic [31:0] reg_rdata_o;
  logic        reg_err_o;
  logic        acc_valid_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [1:0]  acc_kind_i = 2'b11, acc_size_i = '0;
  logic        ss_set_i = 1'b0, task_set_i = 1'b0, stat_clr_i = 1'b0;
  logic        dbg_exc_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_bp [4];
  logic [31:0] m_ctrl;
  logic [3:0]  m_b;
  logic        m_ss, m_task;

  always #4 clk = ~clk;

  hw_bkpt_unit u_hw_bkpt_unit (.clk_i(clk), .*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_stat();
    return {16'h0, m_task, m_ss, 2'b00, 8'hFF, m_b};
  endfunction

  function automatic logic [3:0] m_hits(logic [31:0] a, logic [1:0] kind, logic [1:0] size);
    logic [3:0] h = '0;
    for (int c = 0; c < 4; c++) begin
      logic [1:0] ty = m_ctrl[16+4*c +: 2];
      logic [1:0] ln = m_ctrl[18+4*c +: 2];
      logic [31:0] m;
      int n;
      bit tok;
      if (!(m_ctrl[2*c] || m_ctrl[2*c+1])) continue;
      tok = (ty == 2'b00 && kind == 2'b00) || (ty == 2'b01 && kind == 2'b10) ||
            (ty == 2'b11 && (kind == 2'b01 || kind == 2'b10));
      if (!tok) continue;
      m = (ty == 2'b00 || ln == 2'b00) ? 32'd0 : (ln == 2'b01) ? 32'd1 : 32'd3;
      n = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
      for (int k = 0; k < n; k++) begin
        logic [32:0] byte_a = {1'b0, a} + 33'(k);
        if (!byte_a[32] && ((byte_a[31:0] & ~m) == (m_bp[c] & ~m))) h[c] = 1'b1;
      end
    end
    return h;
  endfunction

  task automatic reg_op(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                        input logic [1:0] pl, output logic [31:0] rd, output logic err);
    reg_req_i = 1'b1; reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd; priv_lvl_i = pl;
    @(posedge clk); @(negedge clk);
    rd = reg_rdata_o; err = reg_err_o;
    reg_req_i = 1'b0; reg_we_i = 1'b0; priv_lvl_i = 2'd0;
    if (we && pl == 2'd0 && sel <= 3'd5) begin
      if (sel < 3'd4) m_bp[sel[1:0]] = wd;
      else if (sel == 3'd4) m_ctrl = wd & 32'hFFFF_20FF;
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] wd);
    logic [31:0] rd; logic err;
    reg_op(1'b1, sel, wd, 2'd0, rd, err);
  endtask

  task automatic rd_check(input string req, input logic [2:0] sel, input logic [31:0] exp);
    logic [31:0] rd; logic err;
    reg_op(1'b0, sel, '0, 2'd0, rd, err);
    check(req, rd, exp);
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic [1:0] kind,
                        input logic [1:0] size, input logic clr);
    logic [3:0] h = m_hits(a, kind, size);
    acc_valid_i = 1'b1; acc_addr_i = a; acc_kind_i = kind; acc_size_i = size; stat_clr_i = clr;
    @(posedge clk); @(negedge clk);
    acc_valid_i = 1'b0; acc_kind_i = 2'b11; stat_clr_i = 1'b0;
    if (clr) begin m_b = '0; m_ss = 1'b0; m_task = 1'b0; end
    m_b |= h;
    check(req, {31'd0, dbg_exc_o}, {31'd0, |h});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic err;
    void'($urandom(32'd7321));
    for (int i = 0; i < 4; i++) m_bp[i] = '0;
    m_ctrl = '0; m_b = '0; m_ss = 1'b0; m_task = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12 reset rdata", reg_rdata_o, 32'h0);
    check("R9 reset exc", {31'd0, dbg_exc_o}, 32'h0);
    rd_check("R2 reset ctrl", 3'd4, 32'h0000_0400);
    rd_check("R3 reset status", 3'd5, 32'h0000_0FF0);

    // R1 address readback
    for (int i = 0; i < 4; i++) begin
      logic [31:0] v = $urandom;
      wr(3'(i), v);
      rd_check("R1 addr readback", 3'(i), v);
    end
    // R2 reserved masking
    wr(3'd4, 32'hFFFF_FFFF);
    rd_check("R2 ctrl all ones", 3'd4, 32'hFFFF_24FF);
    wr(3'd4, 32'h0000_0000);
    rd_check("R2 ctrl zero", 3'd4, 32'h0000_0400);
    // R3 status writes ignored
    wr(3'd5, 32'hFFFF_FFFF);
    rd_check("R3 status write ignored", 3'd5, m_stat());
    // R4 privilege and select errors
    reg_op(1'b1, 3'd0, 32'hDEAD_BEEF, 2'd3, rd, err);
    check("R4 priv err", {31'd0, err}, 32'd1);
    reg_op(1'b0, 3'd0, 32'h0, 2'd1, rd, err);
    check("R4 priv read data", rd, 32'h0);
    reg_op(1'b1, 3'd4, 32'hFFFF_FFFF, 2'd2, rd, err);
    rd_check("R4 addr unchanged", 3'd0, m_bp[0]);
    rd_check("R4 ctrl unchanged", 3'd4, 32'h0000_0400);
    reg_op(1'b0, 3'd6, 32'h0, 2'd0, rd, err);
    check("R4 bad select err", {31'd0, err}, 32'd1);
    check("R4 bad select data", rd, 32'h0);
    @(negedge clk);
    check("R12 idle after err", {31'd0, reg_err_o}, 32'd0);

    // R5 execute breakpoint on channel 0, size field set to 4 bytes but ignored
    wr(3'd0, 32'h0000_1000);
    wr(3'd4, 32'h000C_0001);
    access("R5 fetch exact", 32'h0000_1000, 2'b00, 2'b00, 1'b0);
    access("R5 fetch other byte", 32'h0000_1001, 2'b00, 2'b00, 1'b0);
    access("R5 fetch span covers", 32'h0000_0FFE, 2'b00, 2'b10, 1'b0);
    access("R5 read not exec", 32'h0000_1000, 2'b01, 2'b00, 1'b0);
    @(negedge clk);
    check("R9 single pulse", {31'd0, dbg_exc_o}, 32'd0);
    // R6 types on channel 1
    wr(3'd1, 32'h0000_2000);
    wr(3'd4, 32'h0010_0004);
    access("R6 wr-only read", 32'h0000_2000, 2'b01, 2'b00, 1'b0);
    access("R6 wr-only write", 32'h0000_2000, 2'b10, 2'b00, 1'b0);
    wr(3'd4, 32'h0030_0008);
    access("R6 rw read", 32'h0000_2000, 2'b01, 2'b00, 1'b0);
    access("R6 rw fetch", 32'h0000_2000, 2'b00, 2'b00, 1'b0);
    access("R6 idle kind", 32'h0000_2000, 2'b11, 2'b00, 1'b0);
    wr(3'd4, 32'h0020_000C);
    access("R6 type 10 never", 32'h0000_2000, 2'b10, 2'b00, 1'b0);
    // R7 length and overlap on channel 2, 4-byte region 0x3004..0x3007
    wr(3'd2, 32'h0000_3006);
    wr(3'd4, 32'h0F00_0010);
    access("R7 overlap low", 32'h0000_3002, 2'b10, 2'b11, 1'b0);
    access("R7 below", 32'h0000_3003, 2'b10, 2'b00, 1'b0);
    access("R7 above", 32'h0000_3008, 2'b01, 2'b01, 1'b0);
    wr(3'd4, 32'h0500_0010);
    access("R7 2-byte region", 32'h0000_3007, 2'b01, 2'b00, 1'b0);
    // R8 enables on channel 3
    wr(3'd3, 32'h0000_4000);
    wr(3'd4, 32'h3000_0040);
    access("R8 local", 32'h0000_4000, 2'b01, 2'b00, 1'b0);
    wr(3'd4, 32'h3000_0080);
    access("R8 global", 32'h0000_4000, 2'b01, 2'b00, 1'b0);
    wr(3'd4, 32'h3000_2000);
    access("R8 none", 32'h0000_4000, 2'b01, 2'b00, 1'b0);
    rd_check("R10 sticky bits", 3'd5, m_stat());
    // R10 clear and hit in same cycle, R11 set bits
    wr(3'd4, 32'h3000_0040);
    access("R10 hit during clear", 32'h0000_4000, 2'b10, 2'b00, 1'b1);
    rd_check("R10 hit survives clear", 3'd5, m_stat());
    ss_set_i = 1'b1; task_set_i = 1'b1;
    @(negedge clk);
    ss_set_i = 1'b0; task_set_i = 1'b0; m_ss = 1'b1; m_task = 1'b1;
    rd_check("R11 bits set", 3'd5, m_stat());
    ss_set_i = 1'b1; stat_clr_i = 1'b1;
    @(negedge clk);
    ss_set_i = 1'b0; stat_clr_i = 1'b0; m_b = '0; m_task = 1'b0; m_ss = 1'b1;
    rd_check("R11 set wins clear", 3'd5, m_stat());

    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      if (i % 60 == 0) begin
        wr(3'd4, $urandom);
        for (int c = 0; c < 4; c++) if ($urandom % 3 == 0) wr(3'(c), $urandom & 32'h0000_FFFF);
        rd_check("R10 random status", 3'd5, m_stat());
      end
      a = m_bp[$urandom % 4] + 32'($urandom % 9) - 32'd4;
      access("R9 random access", a, 2'($urandom), 2'($urandom), ($urandom % 40) == 0);
    end
    rd_check("R10 final status", 3'd5, m_stat());

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule